// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block keeps the tap position of a 64-tap resistor string. A host, a quadrature decoder or a debounced pushbutton drives three wires: an active-low select, a step strobe and a direction level. Each falling edge of the strobe moves the wiper one tap while select is low. The direction level chooses which way it moves. The position never wraps. At the top or bottom tap, further strobes in that direction leave it where it is.

All three wires are asynchronous to the system clock. They pass through a two-stage synchroniser, and the strobe's falling edge is found by comparing the synchronised level with the value it had one cycle earlier. The direction level is sampled in that same cycle. Reset loads the middle tap, code 32. The controller outputs the B-side code, the A-side code (63 minus the B-side code) and a one-hot vector that would close one switch of the array. It also gives a single-cycle flag whenever the code really moves.

Top module: `tap_stepper`

## Requirements
- R1: While and after reset the B-side code is 32, the A-side code is 31, only bit 32 of the tap vector is set, and the moved flag is low.
- R2: Only a falling edge of the step strobe moves the code; a rising edge while select is low leaves the code, the tap vector and the moved flag unchanged.
- R3: With select low, a strobe falling edge with direction 1 raises the B-side code by exactly one, and with direction 0 lowers it by exactly one.
- R4: With select high (1), strobe edges and direction changes have no effect on any output.
- R5: At code 63, an up step leaves the code at 63.
- R6: At code 0, a down step leaves the code at 0.
- R7: The A-side code always equals 63 minus the B-side code.
- R8: The tap vector has exactly one bit set, at the index equal to the B-side code, and follows the code one system clock later.
- R9: The moved flag is high for exactly one system clock each time the code changes, and is never raised for a step held at a limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, loads the middle tap |
| sel_n | input | 1 | Active-low select for stepping (asynchronous) |
| step_clk | input | 1 | Step strobe; falling edge moves the wiper (asynchronous) |
| dir_up | input | 1 | Direction: 1 toward A (code up), 0 toward B (code down) |
| code_b | output | 6 | Wiper position counted from terminal B |
| code_a | output | 6 | Complementary position counted from terminal A |
| tap_sel | output | 64 | One-hot switch select, registered from code_b |
| step_done | output | 1 | One-cycle pulse when the code changed |

## Verification
The assertions assume that each strobe level lasts at least two system clocks, so every falling edge reaches the synchroniser output as one clean level change. They also assume that direction and select are steady before the edge and stay steady until it has been sampled. The stimulus holds the strobe high for four cycles and low for at least six. It changes direction and select only while the strobe is idle, at least three cycles before any edge. Because of this, a single falling edge can never be seen as two, and the direction is never caught in transition.

// File: rtl/tap_stepper_pkg.sv
`timescale 1ns/1ps
package tap_stepper_pkg;
    // Decoded step request handed from the edge detector to the position register.
    typedef struct packed {
        logic fire;  // a qualifying strobe falling edge was seen this cycle
        logic up;    // direction sampled in the same cycle
    } step_cmd_t;
endpackage

// File: rtl/tsw_sync.sv
`timescale 1ns/1ps
module tsw_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_d;
    logic [STAGES-1:0][W-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tsw_edge.sv
`timescale 1ns/1ps
module tsw_edge
    import tap_stepper_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_s,
    input  logic      sel_n_s,
    input  logic      dir_s,
    output step_cmd_t cmd_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d     = strobe_s;
        cmd_o.fire = prev_q && !strobe_s && !sel_n_s;
        cmd_o.up   = dir_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tsw_pos.sv
`timescale 1ns/1ps
module tsw_pos
    import tap_stepper_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_cmd_t        cmd_i,
    output logic [POS_W-1:0] code_o,
    output logic             moved_o
);
    localparam logic [POS_W-1:0] TOP = '1;
    localparam logic [POS_W-1:0] BOT = '0;
    localparam logic [POS_W-1:0] MID = POS_W'(1 << (POS_W - 1));

    typedef struct packed {
        logic [POS_W-1:0] code;
        logic             moved;
    } pos_state_t;

    pos_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.moved = 1'b0;
        if (cmd_i.fire) begin
            if (cmd_i.up && st_q.code != TOP) begin
                st_d.code  = st_q.code + 1'b1;
                st_d.moved = 1'b1;
            end else if (!cmd_i.up && st_q.code != BOT) begin
                st_d.code  = st_q.code - 1'b1;
                st_d.moved = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code  <= MID;
            st_q.moved <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign moved_o = st_q.moved;

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({1'b0, st_q.code} == {1'b0, $past(st_q.code)} ||
                          {1'b0, st_q.code} == {1'b0, $past(st_q.code)} + 1'b1 ||
                          {1'b0, st_q.code} + 1'b1 == {1'b0, $past(st_q.code)})); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i.fire |=> $stable(st_q.code)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.fire && cmd_i.up && st_q.code == TOP) |=> st_q.code == TOP); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.fire && !cmd_i.up && st_q.code == BOT) |=> st_q.code == BOT); // R6
    AST_MOVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.moved == (st_q.code != $past(st_q.code)))); // R9
endmodule

// File: rtl/tsw_decode.sv
`timescale 1ns/1ps
module tsw_decode #(
    parameter int POS_W = 6,
    parameter int TAPS  = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] code_i,
    output logic [TAPS-1:0]  tap_o
);
    localparam int MID_IDX = TAPS / 2;

    logic [TAPS-1:0] tap_d, tap_q;

    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_tap
            always_comb tap_d[g] = (code_i == POS_W'(g));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= TAPS'(1) << MID_IDX;
        else        tap_q <= tap_d;
    end

    assign tap_o = tap_q;

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_q) == 1); // R8
    AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tap_q[$past(code_i)]); // R8
endmodule

// File: rtl/tap_stepper.sv
`timescale 1ns/1ps
module tap_stepper
    import tap_stepper_pkg::*;
#(
    parameter int POS_W       = 6,
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 1 << POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             step_clk,
    input  logic             dir_up,
    output logic [POS_W-1:0] code_b,
    output logic [POS_W-1:0] code_a,
    output logic [TAPS-1:0]  tap_sel,
    output logic             step_done
);
    localparam logic [POS_W-1:0] TOP = '1;

    logic [2:0] raw_in, syn_in;
    step_cmd_t  cmd;
    logic [POS_W-1:0] code;

    assign raw_in = {sel_n, step_clk, dir_up};

    tsw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    tsw_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_s (syn_in[1]),
        .sel_n_s  (syn_in[2]),
        .dir_s    (syn_in[0]),
        .cmd_o    (cmd)
    );

    tsw_pos #(.POS_W(POS_W)) pos_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd),
        .code_o  (code),
        .moved_o (step_done)
    );

    tsw_decode #(.POS_W(POS_W), .TAPS(TAPS)) dec_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code),
        .tap_o  (tap_sel)
    );

    assign code_b = code;
    assign code_a = TOP - code;
endmodule

// File: tb/tap_stepper_tb_top.sv
`timescale 1ns/1ps
module tap_stepper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        step_clk = 1'b0;
    logic        dir_up = 1'b0;
    logic [5:0]  code_b, code_a;
    logic [63:0] tap_sel;
    logic        step_done;

    always #2 clk = ~clk;  // 250 MHz

    tap_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .step_clk(step_clk),
        .dir_up(dir_up), .code_b(code_b), .code_a(code_a),
        .tap_sel(tap_sel), .step_done(step_done)
    );

    typedef struct {
        int    code;
        int    pulses;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   pulses = 0;
    int   model = 32;
    int   exp_pulses = 0;
    logic done_prev = 1'b0;

    function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endfunction

    // Pulse counter and width check for the moved flag (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (step_done) pulses++;
            if (step_done && done_prev) chk(1'b0, "R9 width", 64'd2, 64'd1);
            done_prev <= step_done;
        end
    end

    // Monitor: pops expected items and compares them against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(code_b == 6'(e.code), e.tag, 64'(code_b), 64'(e.code));
                chk(code_a == 6'(63 - e.code), "R7", 64'(code_a), 64'(63 - e.code));
                chk(tap_sel == (64'd1 << e.code), "R8", tap_sel, 64'd1 << e.code);
                chk(pulses == e.pulses, "R9", 64'(pulses), 64'(e.pulses));
            end
        end
    end

    task automatic push(string tag);
        exp_t e;
        e.code = model; e.pulses = exp_pulses; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: one full strobe pulse, then the expected result is queued.
    task automatic do_step(bit up, bit cs_n);
        string tag;
        @(negedge clk);
        sel_n = cs_n; dir_up = up;
        repeat (3) @(negedge clk);
        step_clk = 1'b1;
        repeat (4) @(negedge clk);
        step_clk = 1'b0;
        repeat (6) @(negedge clk);
        if (cs_n) tag = "R4";
        else if (up && model == 63) tag = "R5";
        else if (!up && model == 0) tag = "R6";
        else begin
            tag = "R3";
            model = up ? model + 1 : model - 1;
            exp_pulses++;
        end
        push(tag);
        @(negedge clk);
        sel_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(code_b == 6'd32, "R1 code_b", 64'(code_b), 64'd32);
        chk(code_a == 6'd31, "R1 code_a", 64'(code_a), 64'd31);
        chk(tap_sel == (64'd1 << 32), "R1 tap_sel", tap_sel, 64'd1 << 32);
        chk(step_done == 1'b0, "R1 step_done", 64'(step_done), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        push("R1");

        repeat (3) do_step(1'b1, 1'b0);   // R3 up
        repeat (2) do_step(1'b0, 1'b0);   // R3 down
        do_step(1'b1, 1'b1);              // R4 ignored
        do_step(1'b0, 1'b1);              // R4 ignored

        // R2: rising edge alone does nothing; the fall then comes with select high.
        @(negedge clk);
        sel_n = 1'b0; dir_up = 1'b1;
        repeat (3) @(negedge clk);
        step_clk = 1'b1;
        repeat (6) @(negedge clk);
        push("R2");
        @(negedge clk);
        sel_n = 1'b1; dir_up = 1'b0;
        repeat (3) @(negedge clk);
        step_clk = 1'b0;
        repeat (6) @(negedge clk);
        push("R2");

        repeat (34) do_step(1'b1, 1'b0);  // reaches 63 and saturates (R5)
        repeat (67) do_step(1'b0, 1'b0);  // reaches 0 and saturates (R6)
        repeat (2) do_step(1'b1, 1'b0);

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule